// File: doc/BRIEF.md
# Audio Playback DMA Controller

This block sits between a byte-wide configuration bus and a word-wide memory read port. It feeds an audio playback path. Software loads the byte address of the first and the last byte of one buffer period, sets the burst and threshold options, and writes a start command. The block then fetches one word per accepted request, from the word that holds the start address up to and including the word that holds the stop address. Fetching pauses while the downstream FIFO reports full. A stop command abandons the transfer early.

A six-bit interrupt status register collects the completion event and five external events, and software clears it by writing ones. Each status bit reaches the interrupt output only when it is neither muted nor masked. Software can also request a one-cycle FIFO reset pulse. The burst options, threshold, polarity and second configuration byte are held and read back here; the logic that uses them lies outside the block.

Top module: `audio_dma_ctrl`

## Requirements
- R1: After reset the engine is idle (`mem_req` low), the status register reads 0x00, the mute register reads 0x3F, the mask register reads 0xFF, `irq` and `fifo_rst` are low, and every other register reads 0x00.
- R2: The start address is written little-endian as four bytes at 0x3604 (least significant) through 0x3607. The stop address uses 0x3608 through 0x360B in the same way. All bytes read back unchanged at the same offsets.
- R3: Writing 0x3600 stores bits 3..0 (bit 0 burst enable, bits 2..1 burst type, bit 3 bus lock), which read back with bits 7..4 as zero. Bit 7 of the write produces a one-cycle `fifo_rst` pulse in the following cycle. Threshold (0x3603), mask (0x3614), polarity (0x3615), second configuration (0x3616) and buffer polarity (0x361A) are plain byte registers that read back.
- R4: A write with bit 0 set to 0x3601 while idle makes `mem_req` high from the next cycle, with `mem_addr` equal to the start address with its two low bits cleared. `mem_addr` holds while a request waits for `mem_ack`.
- R5: Each cycle with both `mem_req` and `mem_ack` high advances `mem_addr` by 4. The transfer ends after the word whose address bits 31..2 equal those of the stop address is accepted, so the stop address is inclusive.
- R6: While `fifo_full` is high, `mem_req` is low and `mem_addr` does not move. Fetching resumes when it falls.
- R7: A write with bit 0 set to 0x3602 ends a transfer: `mem_req` is low from the next cycle and no done event is raised.
- R8: A start command that arrives during a transfer is ignored; the transfer keeps its address sequence and word count.
- R9: The status register at 0x0109 reads bit 5 error, bit 4 lost, bit 3 retry, bit 2 done, bit 1 buffer full, bit 0 buffer empty. The done bit sets in the cycle after the final word is accepted. Each `evt_in` bit sets the status bit at the same position in the cycle after it is high.
- R10: Writing ones to 0x0109 clears those status bits. A bit that is set by an event in the same cycle stays set.
- R11: `irq` is high when any status bit is set, is not muted (mute register at 0x0189, same bit layout, 1 = muted) and is not masked. Mask bit 7 masks the done bit. Mask bits 5, 4, 3, 1 and 0 mask the status bit at the same position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Byte register write strobe |
| reg_addr | input | 16 | Register byte offset, for writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| evt_in | input | 6 | External event pulses, one per status bit |
| fifo_full | input | 1 | Downstream FIFO full, stalls fetching |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Request accepted and word returned this cycle |
| fifo_rst | output | 1 | One-cycle FIFO reset pulse |
| irq | output | 1 | Interrupt request |

## Verification
All state changes at the clock edge that samples a write, an event or an accepted request. Stored bytes, status bits and the engine state are therefore visible one cycle after that stimulus. `reg_rdata`, `mem_req` and `irq` follow the state without further delay, and `mem_req` also drops in the same cycle that `fifo_full` rises. The bench keeps a behavioural model that it advances on the same edge from the same inputs. It compares the outputs at the falling edge, after the state has settled and before the next stimulus is driven. Directed reads, accepted-word counts and status checks at chosen points back up the comparison made on every clock.

// File: rtl/adc_pkg.sv
package adc_pkg;
    localparam logic [15:0] OFS_CONF0 = 16'h3600;
    localparam logic [15:0] OFS_GO    = 16'h3601;
    localparam logic [15:0] OFS_HALT  = 16'h3602;
    localparam logic [15:0] OFS_THR   = 16'h3603;
    localparam logic [15:0] OFS_SADDR = 16'h3604;
    localparam logic [15:0] OFS_EADDR = 16'h3608;
    localparam logic [15:0] OFS_MASK  = 16'h3614;
    localparam logic [15:0] OFS_POL   = 16'h3615;
    localparam logic [15:0] OFS_CONF1 = 16'h3616;
    localparam logic [15:0] OFS_BPOL  = 16'h361A;
    localparam logic [15:0] OFS_STAT  = 16'h0109;
    localparam logic [15:0] OFS_MUTE  = 16'h0189;
    localparam int          NUM_EVT   = 6;
    localparam int          DONE_BIT  = 2;
    localparam int          DONE_MASK = 7;
endpackage

// File: rtl/adc_regs.sv
module adc_regs
    import adc_pkg::*;
#(
    parameter int AW = 32,
    parameter int WL = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [15:0]        addr,
    input  logic [7:0]         wdata,
    input  logic [NUM_EVT-1:0] status,
    output logic [7:0]         rdata,
    output logic [AW-WL-1:0]   start_word,
    output logic [AW-WL-1:0]   stop_word,
    output logic [NUM_EVT-1:0] mask_gate,
    output logic [NUM_EVT-1:0] mute,
    output logic               go_cmd,
    output logic               halt_cmd,
    output logic [NUM_EVT-1:0] clr,
    output logic               fifo_rst
);
    localparam int NB = AW / 8;

    typedef struct packed {
        logic [AW-1:0]      sa;
        logic [AW-1:0]      ea;
        logic [3:0]         c0;
        logic [7:0]         thr;
        logic [7:0]         c1;
        logic [7:0]         pol;
        logic [7:0]         bpol;
        logic [7:0]         mask;
        logic [NUM_EVT-1:0] mute;
        logic               frst;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d      = q;
        d.frst = 1'b0;
        if (wr) begin
            case (addr)
                OFS_CONF0: begin
                    d.c0   = wdata[3:0];
                    d.frst = wdata[7];
                end
                OFS_THR:   d.thr  = wdata;
                OFS_MASK:  d.mask = wdata;
                OFS_POL:   d.pol  = wdata;
                OFS_CONF1: d.c1   = wdata;
                OFS_BPOL:  d.bpol = wdata;
                OFS_MUTE:  d.mute = wdata[NUM_EVT-1:0];
                default: ;
            endcase
            for (int i = 0; i < NB; i++) begin
                if (addr == OFS_SADDR + 16'(i)) d.sa[8*i +: 8] = wdata;
                if (addr == OFS_EADDR + 16'(i)) d.ea[8*i +: 8] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mask <= 8'hFF;
            q.mute <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata = 8'h00;
        case (addr)
            OFS_CONF0: rdata = {4'h0, q.c0};
            OFS_THR:   rdata = q.thr;
            OFS_MASK:  rdata = q.mask;
            OFS_POL:   rdata = q.pol;
            OFS_CONF1: rdata = q.c1;
            OFS_BPOL:  rdata = q.bpol;
            OFS_STAT:  rdata = 8'(status);
            OFS_MUTE:  rdata = 8'(q.mute);
            default: ;
        endcase
        for (int i = 0; i < NB; i++) begin
            if (addr == OFS_SADDR + 16'(i)) rdata = q.sa[8*i +: 8];
            if (addr == OFS_EADDR + 16'(i)) rdata = q.ea[8*i +: 8];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_EVT; g++) begin : g_gate
            if (g == DONE_BIT) begin : g_done
                assign mask_gate[g] = q.mask[DONE_MASK];
            end else begin : g_evt
                assign mask_gate[g] = q.mask[g];
            end
        end
    endgenerate

    assign start_word = q.sa[AW-1:WL];
    assign stop_word  = q.ea[AW-1:WL];
    assign mute       = q.mute;
    assign fifo_rst   = q.frst;
    assign go_cmd     = wr && (addr == OFS_GO) && wdata[0];
    assign halt_cmd   = wr && (addr == OFS_HALT) && wdata[0];
    assign clr        = (wr && (addr == OFS_STAT)) ? wdata[NUM_EVT-1:0] : '0;
endmodule

// File: rtl/adc_fetch.sv
module adc_fetch #(
    parameter int AW = 32,
    parameter int WL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_cmd,
    input  logic             halt_cmd,
    input  logic [AW-WL-1:0] start_word,
    input  logic [AW-WL-1:0] stop_word,
    input  logic             fifo_full,
    input  logic             mem_ack,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic [AW-WL-1:0] cur;
    } eng_t;

    eng_t q, d;
    logic last, acc;

    assign last     = (q.cur == stop_word);
    assign mem_req  = q.busy && !fifo_full;
    assign mem_addr = {q.cur, {WL{1'b0}}};
    assign acc      = mem_req && mem_ack;
    assign done     = acc && last && !halt_cmd;

    always_comb begin
        d = q;
        if (halt_cmd) begin
            d.busy = 1'b0;
        end else if (!q.busy) begin
            if (go_cmd) begin
                d.busy = 1'b1;
                d.cur  = start_word;
            end
        end else if (acc) begin
            if (last) d.busy = 1'b0;
            else      d.cur  = q.cur + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/adc_irq.sv
module adc_irq
    import adc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               done,
    input  logic [NUM_EVT-1:0] clr,
    input  logic [NUM_EVT-1:0] mask_gate,
    input  logic [NUM_EVT-1:0] mute,
    output logic [NUM_EVT-1:0] status,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_EVT-1:0] st;
    } irq_t;

    irq_t q, d;
    logic [NUM_EVT-1:0] set_v;

    always_comb begin
        set_v           = evt;
        set_v[DONE_BIT] = evt[DONE_BIT] | done;
        d.st            = (q.st & ~clr) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign status = q.st;
    assign irq    = |(q.st & ~mute & ~mask_gate);
endmodule

// File: rtl/audio_dma_ctrl.sv
module audio_dma_ctrl
    import adc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [15:0]         reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_EVT-1:0]  evt_in,
    input  logic                fifo_full,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    output logic                fifo_rst,
    output logic                irq
);
    localparam int WL = $clog2(WORD_BYTES);

    logic [ADDR_W-WL-1:0] start_word_w, stop_word_w;
    logic [NUM_EVT-1:0]   mask_gate_w, mute_w, clr_w, status_w;
    logic                 go_cmd_w, halt_cmd_w, done_w;

    adc_regs #(.AW(ADDR_W), .WL(WL)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .status(status_w), .rdata(reg_rdata), .start_word(start_word_w),
        .stop_word(stop_word_w), .mask_gate(mask_gate_w), .mute(mute_w),
        .go_cmd(go_cmd_w), .halt_cmd(halt_cmd_w), .clr(clr_w), .fifo_rst(fifo_rst)
    );

    adc_fetch #(.AW(ADDR_W), .WL(WL)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go_cmd(go_cmd_w), .halt_cmd(halt_cmd_w),
        .start_word(start_word_w), .stop_word(stop_word_w), .fifo_full(fifo_full),
        .mem_ack(mem_ack), .mem_req(mem_req), .mem_addr(mem_addr), .done(done_w)
    );

    adc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt_in), .done(done_w), .clr(clr_w),
        .mask_gate(mask_gate_w), .mute(mute_w), .status(status_w), .irq(irq)
    );
endmodule

// File: rtl/adc_chk.sv
module adc_chk #(
    parameter int AW = 32,
    parameter int WB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          halt_cmd,
    input logic          done,
    input logic [5:0]    status,
    input logic          irq
);
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> !mem_req || $stable(mem_addr)); // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !done && !halt_cmd |=> mem_addr == $past(mem_addr) + AW'(WB)); // R5
    AST_HALT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cmd |=> !mem_req); // R7
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> status[2]); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        status == 6'h00 |-> !irq); // R11
endmodule

bind audio_dma_ctrl adc_chk #(.AW(ADDR_W), .WB(WORD_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .halt_cmd(halt_cmd_w), .done(done_w),
    .status(status_w), .irq(irq)
);

// File: tb/audio_dma_ctrl_test.sv
module audio_dma_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = 16'h0000;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [5:0]  evt_in = 6'h00;
    logic        fifo_full = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic        fifo_rst;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int n_acc = 0;
    bit ack_en = 1'b0;
    bit ack_alt = 1'b0;
    bit ack_ph = 1'b0;

    always #10 clk = ~clk;

    audio_dma_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .fifo_full(fifo_full), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .fifo_rst(fifo_rst), .irq(irq)
    );

    // behavioural reference state
    logic [31:0] m_sa, m_ea, m_cur;
    logic [7:0]  m_c0, m_thr, m_c1, m_pol, m_bpol, m_mask;
    logic [5:0]  m_mute, m_stat;
    logic        m_busy, m_frst;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        logic [5:0] en;
        en = ~m_mute & ~{m_mask[5], m_mask[4], m_mask[3], m_mask[7], m_mask[1], m_mask[0]};
        return |(m_stat & en);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        case (a)
            16'h3600: return m_c0;
            16'h3603: return m_thr;
            16'h3604: return m_sa[7:0];
            16'h3605: return m_sa[15:8];
            16'h3606: return m_sa[23:16];
            16'h3607: return m_sa[31:24];
            16'h3608: return m_ea[7:0];
            16'h3609: return m_ea[15:8];
            16'h360A: return m_ea[23:16];
            16'h360B: return m_ea[31:24];
            16'h3614: return m_mask;
            16'h3615: return m_pol;
            16'h3616: return m_c1;
            16'h361A: return m_bpol;
            16'h0109: return {2'b00, m_stat};
            16'h0189: return {2'b00, m_mute};
            default:  return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sa = 0; m_ea = 0; m_cur = 0; m_c0 = 0; m_thr = 0; m_c1 = 0;
            m_pol = 0; m_bpol = 0; m_mask = 8'hFF; m_mute = 6'h3F; m_stat = 0;
            m_busy = 0; m_frst = 0;
        end else begin
            bit req, acc, last, done, go, halt;
            req  = m_busy && !fifo_full;
            acc  = req && mem_ack;
            last = (m_cur[31:2] == m_ea[31:2]);
            go   = reg_wr && reg_addr == 16'h3601 && reg_wdata[0];
            halt = reg_wr && reg_addr == 16'h3602 && reg_wdata[0];
            done = acc && last && !halt;
            if (acc) n_acc++;
            m_stat = (m_stat & ~((reg_wr && reg_addr == 16'h0109) ? reg_wdata[5:0] : 6'h00))
                     | evt_in | (done ? 6'h04 : 6'h00);
            if (halt) m_busy = 0;
            else if (!m_busy && go) begin
                m_busy = 1;
                m_cur = {m_sa[31:2], 2'b00};
            end else if (m_busy && acc) begin
                if (last) m_busy = 0;
                else m_cur = m_cur + 4;
            end
            m_frst = reg_wr && reg_addr == 16'h3600 && reg_wdata[7];
            if (reg_wr) begin
                case (reg_addr)
                    16'h3600: m_c0 = {4'h0, reg_wdata[3:0]};
                    16'h3603: m_thr = reg_wdata;
                    16'h3604: m_sa[7:0] = reg_wdata;
                    16'h3605: m_sa[15:8] = reg_wdata;
                    16'h3606: m_sa[23:16] = reg_wdata;
                    16'h3607: m_sa[31:24] = reg_wdata;
                    16'h3608: m_ea[7:0] = reg_wdata;
                    16'h3609: m_ea[15:8] = reg_wdata;
                    16'h360A: m_ea[23:16] = reg_wdata;
                    16'h360B: m_ea[31:24] = reg_wdata;
                    16'h3614: m_mask = reg_wdata;
                    16'h3615: m_pol = reg_wdata;
                    16'h3616: m_c1 = reg_wdata;
                    16'h361A: m_bpol = reg_wdata;
                    16'h0189: m_mute = reg_wdata[5:0];
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 R6 mem_req", mem_req, m_busy && !fifo_full);
            if (m_busy) chk("R5 mem_addr", mem_addr, m_cur);
            chk("R11 irq", irq, exp_irq());
            chk("R3 fifo_rst", fifo_rst, m_frst);
            chk(reg_addr == 16'h0109 ? "R9 rdata" : "R2 rdata", reg_rdata, exp_rd(reg_addr));
        end
    end

    // memory acknowledge driver
    always @(negedge clk) begin
        #2;
        ack_ph = ~ack_ph;
        mem_ack = mem_req && ack_en && (!ack_alt || ack_ph);
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        reg_addr = a;
        #5 chk(tag, reg_rdata, exp);
    endtask

    task automatic wr32(input logic [15:0] a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(a + 16'(i), v[8*i +: 8]);
    endtask

    initial begin
        #(20 * 100000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int acc0;
        repeat (3) @(negedge clk);
        #5;
        chk("R1 mem_req in reset", mem_req, 1'b0);
        chk("R1 irq in reset", irq, 1'b0);
        rst_n = 1'b1;
        rd(16'h3614, 8'hFF, "R1 mask reset");
        rd(16'h0189, 8'h3F, "R1 mute reset");
        rd(16'h0109, 8'h00, "R1 status reset");
        rd(16'h3604, 8'h00, "R1 start addr reset");
        chk("R1 fifo_rst reset", fifo_rst, 1'b0);

        // addresses, little-endian bytes
        wr32(16'h3604, 32'h1000_0012);
        wr32(16'h3608, 32'h1000_001F);
        rd(16'h3604, 8'h12, "R2 start byte0");
        rd(16'h3607, 8'h10, "R2 start byte3");
        rd(16'h3608, 8'h1F, "R2 stop byte0");

        // configuration bytes and FIFO reset pulse
        wr(16'h3600, 8'h8B);
        rd(16'h3600, 8'h0B, "R3 conf0 readback");
        wr(16'h3603, 8'h80);
        wr(16'h3616, 8'h3F);
        wr(16'h3615, 8'hFF);
        wr(16'h361A, 8'hA5);
        rd(16'h3616, 8'h3F, "R3 conf1 readback");
        rd(16'h361A, 8'hA5, "R3 buffer polarity readback");

        // full transfer, done unmuted and unmasked
        wr(16'h0189, 6'h3B);
        wr(16'h3614, 8'h7F);
        ack_en = 1'b1;
        acc0 = n_acc;
        wr(16'h3601, 8'h01);
        repeat (12) @(negedge clk);
        #5;
        chk("R5 words accepted inclusive stop", n_acc - acc0, 4);
        chk("R11 irq on done", irq, 1'b1);
        rd(16'h0109, 8'h04, "R9 done status");
        wr(16'h0109, 8'h04);
        rd(16'h0109, 8'h00, "R10 done cleared");
        chk("R10 irq after clear", irq, 1'b0);

        // stall, and a start command while busy
        ack_alt = 1'b1;
        acc0 = n_acc;
        wr(16'h3601, 8'h01);
        wr(16'h3601, 8'h01);
        @(negedge clk); #1;
        fifo_full = 1'b1;
        #5 chk("R6 mem_req low when full", mem_req, 1'b0);
        repeat (3) @(negedge clk);
        #1 fifo_full = 1'b0;
        repeat (16) @(negedge clk);
        #5;
        chk("R8 word count with repeated start", n_acc - acc0, 4);
        wr(16'h0109, 8'h3F);

        // abort without done
        ack_en = 1'b0;
        wr(16'h3601, 8'h01);
        repeat (2) @(negedge clk);
        #5 chk("R4 request pending", mem_req, 1'b1);
        chk("R4 first address aligned", mem_addr, 32'h1000_0010);
        wr(16'h3602, 8'h01);
        #5 chk("R7 request dropped", mem_req, 1'b0);
        rd(16'h0109, 8'h00, "R7 no done after abort");
        ack_en = 1'b1;

        // external events, muting, masking
        @(negedge clk); #1 evt_in = 6'h21;
        @(negedge clk); #1 evt_in = 6'h00;
        rd(16'h0109, 8'h21, "R9 event status");
        chk("R11 muted events", irq, 1'b0);
        wr(16'h0189, 8'h00);
        #5 chk("R11 masked events", irq, 1'b0);
        wr(16'h3614, 8'h00);
        #5 chk("R11 unmasked events", irq, 1'b1);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = 16'h0109; reg_wdata = 8'h21; evt_in = 6'h01;
        @(negedge clk); #1;
        reg_wr = 1'b0; evt_in = 6'h00;
        rd(16'h0109, 8'h01, "R10 set wins over clear");
        wr(16'h0109, 8'h01);

        // done masked by mask bit 7
        ack_alt = 1'b0;
        wr(16'h3614, 8'h80);
        wr(16'h3601, 8'h01);
        repeat (10) @(negedge clk);
        #5 chk("R11 done masked by bit 7", irq, 1'b0);
        rd(16'h0109, 8'h04, "R9 done still recorded");
        wr(16'h3614, 8'h00);
        #5 chk("R11 done unmasked", irq, 1'b1);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule